// File: doc/BRIEF.md
# AHB-Lite Byte-Addressable Memory Subordinate

This block is an AHB-Lite subordinate that holds a small memory, sized in bytes by a parameter, and serves byte, halfword and word reads and writes on a 32-bit data bus. A transfer is taken in its address phase. It is then finished in the data phase. Write data is taken in the data phase. Read data is presented in the data phase, in the cycle in which the ready output is high.

A per-cycle availability input lets the surrounding system stretch any normal data phase with wait states. An illegal access is answered with an error sequence and leaves the memory untouched. An access is illegal when its address is not aligned to the bus width, when it lies past the end of the memory, or when its size is wider than the bus. The error sequence always takes three cycles:
- one wait cycle with the response OKAY,
- one wait cycle with the response ERROR,
- one completing cycle with the response ERROR.

The bus in this block has no streaming data path, so there is no valid/ready pair. The flow-control rules are those of AHB-Lite: the ready output stretches the data phase, and the address phase is never stalled. Reset is asynchronous and active-low.

Top module: `ahbl_sram_slave`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `readyout_o` is 1 and `resp_o` is 0 (OKAY).
- R2: A cycle with `sel_i` low, or with `trans_i` equal to IDLE (2'b00) or BUSY (2'b01), is not a transfer. The next cycle shows `readyout_o`=1 and `resp_o`=0, and the memory does not change.
- R3: A legal write updates only its active byte lanes. `size_i`=0 updates lane 0 (bits 7:0), 1 updates lanes 0-1 (bits 15:0), and 2 updates all four lanes. Write data is taken from `wdata_i` in the cycle in which the data phase completes.
- R4: A legal read returns the stored bytes on its active lanes, with the lanes chosen by `size_i` as in R3. All other bits of `rdata_o` are 0.
- R5: In a legal data phase, `readyout_o` follows `avail_i` in each cycle and `resp_o` stays OKAY. With N leading cycles of `avail_i`=0, the phase takes N wait cycles.
- R6: An access is answered with the error sequence when `addr_i[1:0]` is not 0, or when `size_i` is greater than 2. The sequence is `readyout_o`/`resp_o` = 0/0, then 0/1, then 1/1, whatever `avail_i` does. A write answered this way changes nothing.
- R7: An access with `addr_i` at or above `MEM_BYTES` gets the same error sequence and changes nothing, including the word its low address bits would alias to.
- R8: `readyout_o` is low only inside a data phase. When no transfer is pending, `readyout_o` is 1 and `resp_o` is 0.
- R9: A transfer is accepted only when `ready_i` is 1. An active transfer presented with `ready_i`=0 has no effect.
- R10: Back-to-back transfers are supported. A new address phase may overlap the completing data phase, and a read of a word written in the immediately preceding transfer returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Subordinate select |
| addr_i | input | ADDR_W | Byte address (address phase) |
| trans_i | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| write_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 3 | log2 of transfer bytes |
| wdata_i | input | DATA_W | Write data (data phase) |
| ready_i | input | 1 | Bus-wide ready; qualifies address sampling |
| avail_i | input | 1 | 1 = may complete the data phase this cycle, 0 = insert a wait state |
| readyout_o | output | 1 | Ready output of this subordinate |
| resp_o | output | 1 | Response: 0 OKAY, 1 ERROR |
| rdata_o | output | DATA_W | Read data, zero outside the active lanes |

## Verification
The assertions check the following on every cycle:
- the ready/response pair during reset;
- that an error response is always led by an OKAY wait state;
- that the low ERROR cycle is always followed by the high ERROR cycle;
- that the ready output is high whenever no data phase is open;
- that a cycle with no accepted transfer leads to a zero-wait OKAY.

Some behaviours can only be shown by the bench's scenarios, because they depend on memory contents:
- lane masking of writes and reads;
- that rejected writes, and transfers seen while `ready_i` is low, leave the memory unchanged;
- that the stall length matches the availability pattern;
- read-after-write ordering in pipelined transfers.

// File: rtl/ahbl_sram_pkg.sv
package ahbl_sram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_DATA     = 3'd1,
    PH_ERR_WAIT = 3'd2,
    PH_ERR_LOW  = 3'd3,
    PH_ERR_HIGH = 3'd4
  } phase_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam logic RSP_OKAY  = 1'b0;
  localparam logic RSP_ERROR = 1'b1;

  // Active transfer: NONSEQ or SEQ share the high bit.
  function automatic logic is_active(input logic [1:0] tr);
    return tr[1];
  endfunction

endpackage

// File: rtl/ahbl_addr_check.sv
module ahbl_addr_check #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MEM_BYTES = 1024,
  localparam int LANES    = DATA_W / 8,
  localparam int LANE_AW  = $clog2(LANES),
  localparam int WORDS    = MEM_BYTES / LANES,
  localparam int WORD_AW  = $clog2(WORDS)
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [2:0]         size_i,
  output logic               legal_o,
  output logic [LANES-1:0]   lane_en_o,
  output logic [WORD_AW-1:0] word_idx_o
);

  localparam logic [ADDR_W-1:0] LIMIT    = ADDR_W'(MEM_BYTES);
  localparam logic [2:0]        MAX_SIZE = 3'(LANE_AW);

  logic aligned;
  logic in_range;
  logic size_ok;

  assign aligned  = (addr_i[LANE_AW-1:0] == '0);
  assign in_range = (addr_i < LIMIT);
  assign size_ok  = (size_i <= MAX_SIZE);
  assign legal_o  = aligned && in_range && size_ok;

  // Aligned accesses always start at lane 0; the size sets how many lanes.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en_o[g] = (32'(g) < (32'd1 << size_i));
  end

  assign word_idx_o = addr_i[LANE_AW +: WORD_AW];

endmodule

// File: rtl/ahbl_phase_ctrl.sv
module ahbl_phase_ctrl
  import ahbl_sram_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int WORD_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept_i,
  input  logic               legal_i,
  input  logic               write_i,
  input  logic [LANES-1:0]   lane_en_i,
  input  logic [WORD_AW-1:0] word_idx_i,
  input  logic               avail_i,
  output phase_e             phase_o,
  output logic               readyout_o,
  output logic               resp_o,
  output logic               wr_fire_o,
  output logic               rd_active_o,
  output logic [LANES-1:0]   lane_en_o,
  output logic [WORD_AW-1:0] word_idx_o
);

  phase_e             phase_q, phase_d;
  logic               write_q;
  logic [LANES-1:0]   lanes_q;
  logic [WORD_AW-1:0] idx_q;
  logic               done;

  // The current phase is closed this cycle, so a new address may be taken.
  always_comb begin
    unique case (phase_q)
      PH_IDLE:     done = 1'b1;
      PH_DATA:     done = avail_i;
      PH_ERR_HIGH: done = 1'b1;
      default:     done = 1'b0;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_ERR_WAIT: phase_d = PH_ERR_LOW;
      PH_ERR_LOW:  phase_d = PH_ERR_HIGH;
      default: begin
        if (done) begin
          if (accept_i) phase_d = legal_i ? PH_DATA : PH_ERR_WAIT;
          else          phase_d = PH_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      write_q <= 1'b0;
      lanes_q <= '0;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (done && accept_i) begin
        write_q <= write_i;
        lanes_q <= lane_en_i;
        idx_q   <= word_idx_i;
      end
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_IDLE:     begin readyout_o = 1'b1;    resp_o = RSP_OKAY;  end
      PH_DATA:     begin readyout_o = avail_i; resp_o = RSP_OKAY;  end
      PH_ERR_WAIT: begin readyout_o = 1'b0;    resp_o = RSP_OKAY;  end
      PH_ERR_LOW:  begin readyout_o = 1'b0;    resp_o = RSP_ERROR; end
      PH_ERR_HIGH: begin readyout_o = 1'b1;    resp_o = RSP_ERROR; end
      default:     begin readyout_o = 1'b1;    resp_o = RSP_OKAY;  end
    endcase
  end

  assign wr_fire_o   = (phase_q == PH_DATA) && avail_i && write_q;
  assign rd_active_o = (phase_q == PH_DATA) && !write_q;
  assign lane_en_o   = lanes_q;
  assign word_idx_o  = idx_q;
  assign phase_o     = phase_q;

endmodule

// File: rtl/ahbl_byte_mem.sv
module ahbl_byte_mem #(
  parameter int DATA_W  = 32,
  parameter int WORDS   = 256,
  localparam int LANES  = DATA_W / 8,
  localparam int WORD_AW = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [LANES-1:0]   lane_en_i,
  input  logic [WORD_AW-1:0] idx_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] store [WORDS];

    always_ff @(posedge clk) begin
      if (wr_en_i && lane_en_i[g]) store[idx_i] <= wdata_i[8*g +: 8];
    end

    assign rdata_o[8*g +: 8] = (rd_en_i && lane_en_i[g]) ? store[idx_i] : 8'h00;
  end

endmodule

// File: rtl/ahbl_sram_slave.sv
module ahbl_sram_slave
  import ahbl_sram_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MEM_BYTES = 1024,
  localparam int LANES    = DATA_W / 8,
  localparam int WORDS    = MEM_BYTES / LANES,
  localparam int WORD_AW  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        trans_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  input  logic              avail_i,
  output logic              readyout_o,
  output logic              resp_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic               accept;
  logic               legal;
  logic [LANES-1:0]   lane_en_a;
  logic [WORD_AW-1:0] idx_a;
  logic [LANES-1:0]   lane_en_d;
  logic [WORD_AW-1:0] idx_d;
  logic               wr_fire;
  logic               rd_active;
  phase_e             phase_w;

  assign accept = sel_i && is_active(trans_i) && ready_i;

  ahbl_addr_check #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES)
  ) u_check (
    .addr_i     (addr_i),
    .size_i     (size_i),
    .legal_o    (legal),
    .lane_en_o  (lane_en_a),
    .word_idx_o (idx_a)
  );

  ahbl_phase_ctrl #(
    .LANES(LANES), .WORD_AW(WORD_AW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .legal_i     (legal),
    .write_i     (write_i),
    .lane_en_i   (lane_en_a),
    .word_idx_i  (idx_a),
    .avail_i     (avail_i),
    .phase_o     (phase_w),
    .readyout_o  (readyout_o),
    .resp_o      (resp_o),
    .wr_fire_o   (wr_fire),
    .rd_active_o (rd_active),
    .lane_en_o   (lane_en_d),
    .word_idx_o  (idx_d)
  );

  ahbl_byte_mem #(
    .DATA_W(DATA_W), .WORDS(WORDS)
  ) u_mem (
    .clk       (clk),
    .wr_en_i   (wr_fire),
    .rd_en_i   (rd_active),
    .lane_en_i (lane_en_d),
    .idx_i     (idx_d),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o)
  );

endmodule

// File: rtl/ahbl_sram_checker.sv
module ahbl_sram_checker
  import ahbl_sram_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sel_i,
  input logic [1:0] trans_i,
  input logic       ready_i,
  input logic       readyout_o,
  input logic       resp_o,
  input phase_e     phase
);

  // R1: ready high and OKAY while reset is held
  a_r1_reset_ready: assert property (@(posedge clk)
    !rst_n |-> (readyout_o && !resp_o));

  // R6: a low ERROR cycle is followed by a high ERROR cycle
  a_r6_err_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_o && !readyout_o) |=> (resp_o && readyout_o));

  // R6: the first ERROR cycle has ready low
  a_r6_err_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_o) |-> !readyout_o);

  // R6: the low ERROR cycle is led by an OKAY wait state
  a_r6_err_led_by_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_o) |-> $past(!readyout_o && !resp_o));

  // R8: no open data phase means ready and OKAY
  a_r8_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (readyout_o && !resp_o));

  // R2, R9: a closing cycle with no accepted transfer leads to a zero-wait OKAY
  a_r2_no_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (readyout_o && !(sel_i && trans_i[1] && ready_i)) |=> (readyout_o && !resp_o));

endmodule

bind ahbl_sram_slave ahbl_sram_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_i      (sel_i),
  .trans_i    (trans_i),
  .ready_i    (ready_i),
  .readyout_o (readyout_o),
  .resp_o     (resp_o),
  .phase      (phase_w)
);

// File: tb/ahbl_sram_slave_tb_top.sv
`timescale 1ns/1ps
module ahbl_sram_slave_tb_top;

  localparam int MEMB  = 1024;
  localparam int NWORD = MEMB / 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  trans_i = 2'b00;
  logic        write_i = 1'b0;
  logic [2:0]  size_i = 3'd2;
  logic [31:0] wdata_i = '0;
  logic        avail_i = 1'b1;
  logic        hold_low = 1'b0;
  logic        ready_w;
  logic        readyout_o;
  logic        resp_o;
  logic [31:0] rdata_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] model [NWORD];

  always #2.5 clk = ~clk;

  assign ready_w = hold_low ? 1'b0 : readyout_o;

  ahbl_sram_slave #(.ADDR_W(32), .DATA_W(32), .MEM_BYTES(MEMB)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .addr_i(addr_i), .trans_i(trans_i),
    .write_i(write_i), .size_i(size_i), .wdata_i(wdata_i), .ready_i(ready_w),
    .avail_i(avail_i), .readyout_o(readyout_o), .resp_o(resp_o), .rdata_o(rdata_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lmask(input logic [2:0] sz);
    return (sz == 3'd0) ? 32'h0000_00FF : (sz == 3'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  // One non-pipelined transfer; caller starts right after a negedge.
  task automatic xfer(input bit wr, input logic [31:0] a, input logic [2:0] sz,
                      input logic [31:0] wd, input int stall,
                      output logic [31:0] rd, output bit err, output int waits,
                      output bit seq_ok);
    bit lr0, lr1;
    lr0 = 1'b1; lr1 = 1'b0; waits = 0; rd = '0; err = 1'b0;
    sel_i = 1'b1; trans_i = 2'b10; addr_i = a; write_i = wr; size_i = sz;
    @(posedge clk);
    @(negedge clk);
    sel_i = 1'b0; trans_i = 2'b00; wdata_i = wd;
    for (int k = 0; k < 40; k++) begin
      if (k != 0) @(negedge clk);
      avail_i = (waits >= stall);
      #1;
      if (readyout_o) begin
        rd = rdata_o; err = resp_o;
        break;
      end
      if (waits == 0) lr0 = resp_o;
      if (waits == 1) lr1 = resp_o;
      waits++;
    end
    seq_ok = (lr0 == 1'b0) && (lr1 == 1'b1) && (waits == 2) && err;
    @(posedge clk);
    @(negedge clk);
    avail_i = 1'b1;
  endtask

  task automatic wr_word(input logic [31:0] a, input logic [2:0] sz,
                         input logic [31:0] wd, input int stall, input string req);
    logic [31:0] rd; bit err, sq; int w;
    xfer(1'b1, a, sz, wd, stall, rd, err, w, sq);
    chk(!err && w == stall, req, "write wait/ok", 32'(w), 32'(stall));
    model[a[9:2]] = (model[a[9:2]] & ~lmask(sz)) | (wd & lmask(sz));
  endtask

  task automatic rd_word(input logic [31:0] a, input logic [2:0] sz,
                         input int stall, input string req);
    logic [31:0] rd; bit err, sq; int w;
    xfer(1'b0, a, sz, '0, stall, rd, err, w, sq);
    chk(!err && w == stall, req, "read wait/ok", 32'(w), 32'(stall));
    chk(rd == (model[a[9:2]] & lmask(sz)), req, "read data", rd, model[a[9:2]] & lmask(sz));
  endtask

  task automatic bad_xfer(input bit wr, input logic [31:0] a, input logic [2:0] sz,
                          input string req);
    logic [31:0] rd; bit err, sq; int w;
    xfer(wr, a, sz, 32'hDEAD_BEEF, 3, rd, err, w, sq);
    chk(sq, req, "error sequence", 32'(w), 32'd2);
    chk(readyout_o && !resp_o, req, "ready after error", {30'd0, readyout_o, resp_o}, 32'd2);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd; bit err, sq; int w;
    repeat (3) @(negedge clk);
    #1;
    chk(readyout_o && !resp_o, "R1", "in reset", {30'd0, readyout_o, resp_o}, 32'd2);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(readyout_o && !resp_o, "R1", "after reset", {30'd0, readyout_o, resp_o}, 32'd2);

    // R3/R4/R5: full word sweep with varied stalls
    for (int i = 0; i < NWORD; i++) begin
      model[i] = '0;
      wr_word(32'(i * 4), 3'd2, (32'(i) * 32'h0101_0101) ^ 32'h5A3C_96E1, i % 3, "R3");
    end
    for (int i = 0; i < NWORD; i++) rd_word(32'(i * 4), 3'd2, (i + 1) % 4, "R5");

    // R3/R4: partial-lane writes and reads
    for (int i = 0; i < NWORD; i += 17) begin
      for (int s = 0; s < 2; s++) begin
        wr_word(32'(i * 4), 3'(s), 32'hC0DE_0000 | 32'(i * 7 + s), 0, "R3");
        rd_word(32'(i * 4), 3'd2, 0, "R3");
        rd_word(32'(i * 4), 3'(s), 1, "R4");
      end
    end

    // R6: misaligned and oversized accesses
    for (int off = 1; off < 4; off++)
      for (int s = 0; s < 3; s++) bad_xfer(1'b1, 32'(40 + off), 3'(s), "R6");
    bad_xfer(1'b1, 32'd40, 3'd3, "R6");
    bad_xfer(1'b0, 32'd42, 3'd1, "R6");
    rd_word(32'd40, 3'd2, 0, "R6");

    // R7: out of range, including aliasing onto word 0
    bad_xfer(1'b1, MEMB, 3'd2, "R7");
    bad_xfer(1'b1, 32'hFFFF_FFFC, 3'd2, "R7");
    bad_xfer(1'b0, MEMB + 4, 3'd2, "R7");
    rd_word(32'd0, 3'd2, 0, "R7");
    rd_word(32'd4, 3'd2, 0, "R7");

    // R2: IDLE, BUSY and unselected cycles do nothing
    for (int m = 0; m < 3; m++) begin
      sel_i = (m != 2); trans_i = (m == 0) ? 2'b00 : (m == 1) ? 2'b01 : 2'b10;
      addr_i = 32'd8; write_i = 1'b1; size_i = 3'd2;
      @(posedge clk); @(negedge clk);
      sel_i = 1'b0; trans_i = 2'b00; wdata_i = 32'h1111_2222; avail_i = 1'b0;
      #1;
      chk(readyout_o && !resp_o, "R2", "zero-wait okay", {30'd0, readyout_o, resp_o}, 32'd2);
      avail_i = 1'b1;
      @(negedge clk);
      rd_word(32'd8, 3'd2, 0, "R2");
    end

    // R9: active transfer while ready_i low is ignored
    hold_low = 1'b1;
    sel_i = 1'b1; trans_i = 2'b10; addr_i = 32'd12; write_i = 1'b1; size_i = 3'd2;
    @(posedge clk); @(negedge clk);
    hold_low = 1'b0; sel_i = 1'b0; trans_i = 2'b00; wdata_i = 32'h7777_7777; avail_i = 1'b0;
    #1;
    chk(readyout_o && !resp_o, "R9", "not accepted", {30'd0, readyout_o, resp_o}, 32'd2);
    avail_i = 1'b1;
    @(negedge clk);
    rd_word(32'd12, 3'd2, 0, "R9");

    // R10: pipelined write then read of the same word
    sel_i = 1'b1; trans_i = 2'b10; addr_i = 32'd100; write_i = 1'b1; size_i = 3'd2;
    @(posedge clk); @(negedge clk);
    trans_i = 2'b10; addr_i = 32'd104; write_i = 1'b1; wdata_i = 32'hAAAA_0001;
    #1; chk(readyout_o, "R10", "first data phase ready", {31'd0, readyout_o}, 32'd1);
    @(posedge clk); @(negedge clk);
    trans_i = 2'b10; addr_i = 32'd104; write_i = 1'b0; wdata_i = 32'hBBBB_0002;
    @(posedge clk); @(negedge clk);
    sel_i = 1'b0; trans_i = 2'b00;
    #1;
    chk(rdata_o == 32'hBBBB_0002 && !resp_o, "R10", "read after write", rdata_o, 32'hBBBB_0002);
    model[25] = 32'hAAAA_0001; model[26] = 32'hBBBB_0002;
    @(negedge clk);
    rd_word(32'd100, 3'd2, 0, "R10");

    // R8: idle bus keeps ready high
    repeat (2) @(negedge clk);
    #1;
    chk(readyout_o && !resp_o, "R8", "idle ready", {30'd0, readyout_o, resp_o}, 32'd2);

    finish_run();
  end

endmodule